// File: doc/BRIEF.md
# Bus Controller Frame Scheduler

This block walks a frame list of bus controller entries held in a local memory. It launches each message by pulsing a start strobe to a separate transmit engine, together with the message number and the selected bus channel (A or B). Messages are spaced by their start times, not by the idle time between them. Each entry holds a spacing value in microsecond ticks. The next launch happens only when that spacing has run out and the transmit engine has reported the previous message complete. A spacing shorter than the minimum intermessage gap is raised to that minimum.

The list can also hold symbols that are not messages:
- A skip symbol is passed over.
- An end-of-minor symbol holds the list until the next minor-frame boundary. Boundaries come from a programmable tick counter, so all minor frames have the same length.
- An end-of-major symbol returns the list to entry 0 and restarts the minor-frame counter.

A host may request one asynchronous message while the list is running. That message is launched at the next launch opportunity, before the next list entry. The list then resumes where it left off.

Top module: `bc_frame_sched`

## Requirements
- R1: While reset is asserted, start_o, async_o and minor_o are 0 and list_addr_o is 0.
- R2: A list entry is read at list_addr_o with these fields: kind in bits [28:27], bus in bit [26] (0 selects channel A, 1 selects channel B), message number in [25:16], and spacing in [15:0]. A kind of 0 is a message. Launching a message gives a one-cycle start_o pulse carrying that entry's bus and message number, and list_addr_o advances by one.
- R3: A 1 µs tick is produced every TICK_DIV clocks. The next launch happens no earlier than the spacing value in ticks after the previous start.
- R4: A spacing value below MIN_GAP is treated as MIN_GAP ticks.
- R5: A launch waits for the done_i pulse of the previous message. When the spacing has already expired, start_o rises in the cycle after done_i, plus one cycle for each symbol consumed in between.
- R6: An end-of-major entry (kind 2) sets list_addr_o to 0, restarts the minor-frame counter and pulses minor_o while list_addr_o is 0. It produces no start_o.
- R7: An end-of-minor entry (kind 1) holds the list until the minor counter wraps. The entry that follows is launched in the cycle after that wrap's minor_o pulse.
- R8: When it is not restarted, the minor counter pulses minor_o once every minor_period_i ticks.
- R9: async_req_i with a message-kind async_entry_i is latched while running. The latched message is launched at the next launch opportunity, ahead of the list, with async_o high. The list then continues at the same address, spaced from the asynchronous start by the asynchronous entry's own spacing.
- R10: A skip entry (kind 3) advances list_addr_o without a start and costs one cycle.
- R11: While run_i is low, list_addr_o is 0, no start is produced and async_req_i is ignored. After run_i rises, the first launch is list entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Scheduler runs while high |
| minor_period_i | input | MINOR_W | Minor-frame length in ticks |
| list_addr_o | output | ADDR_W | Frame list read address |
| list_entry_i | input | ENTRY_W | Entry at list_addr_o, same cycle |
| async_req_i | input | 1 | Asynchronous message request |
| async_entry_i | input | ENTRY_W | Asynchronous message entry |
| done_i | input | 1 | Message completion pulse from the transmit engine |
| start_o | output | 1 | Message start strobe |
| bus_o | output | 1 | Channel select, 0 is A and 1 is B |
| msg_o | output | MSG_W | Message number of the launch |
| async_o | output | 1 | The current start is the asynchronous message |
| minor_o | output | 1 | Minor-frame boundary pulse |

## Verification
The bench builds the block with TICK_DIV=4, MIN_GAP=5, ADDR_W=4 and MINOR_W=16. With these values, random spacings of 0 to 12 ticks land on both sides of the stretch threshold. A 20-tick minor frame wraps within 80 clocks, and the 16-entry list wraps quickly. Done delays are drawn both below and above the spacing window, so both the spacing limit and the done hold-off decide the launch cycle at different times.

// File: rtl/bc_sched_pkg.sv
`timescale 1ns/1ps
package bc_sched_pkg;
  localparam int MSG_W = 10;
  localparam int GAP_W = 16;

  typedef enum logic [1:0] {
    K_MSG       = 2'd0,
    K_END_MINOR = 2'd1,
    K_END_MAJOR = 2'd2,
    K_SKIP      = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic             bus_b;
    logic [MSG_W-1:0] msg;
    logic [GAP_W-1:0] gap;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/bcs_tick.sv
`timescale 1ns/1ps
module bcs_tick #(
  parameter int DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(DIV - 1));
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i || wrap) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcs_minor.sv
`timescale 1ns/1ps
module bcs_minor #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         restart_i,
  input  logic [W-1:0] period_i,
  output logic         wrap_o,
  output logic         mark_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && tick_i && (cnt_q == period_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mark_o <= 1'b0;
    end else begin
      mark_o <= en_i && (wrap_o || restart_i);
      if (!en_i || restart_i || wrap_o) cnt_q <= '0;
      else if (tick_i)                  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bcs_spacing.sv
`timescale 1ns/1ps
module bcs_spacing #(
  parameter int GW      = 16,
  parameter int MIN_GAP = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          launch_i,
  input  logic [GW-1:0] gap_i,
  input  logic          done_i,
  output logic          ready_o
);
  localparam logic [GW-1:0] SAT  = '1;
  localparam logic [GW-1:0] MING = GW'(MIN_GAP);

  logic [GW-1:0] elapsed_q, need_q;
  logic          busy_q;

  // start-to-start window, then wait for completion
  assign ready_o = (elapsed_q >= need_q) && (!busy_q || done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= SAT;
      need_q    <= '0;
      busy_q    <= 1'b0;
    end else if (!en_i) begin
      elapsed_q <= SAT;
      need_q    <= '0;
      busy_q    <= 1'b0;
    end else if (launch_i) begin
      elapsed_q <= '0;
      need_q    <= (gap_i < MING) ? MING : gap_i;
      busy_q    <= 1'b1;
    end else begin
      if (tick_i && elapsed_q != SAT) elapsed_q <= elapsed_q + 1'b1;
      if (done_i) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bc_frame_sched.sv
`timescale 1ns/1ps
module bc_frame_sched
  import bc_sched_pkg::*;
#(
  parameter int TICK_DIV = 50,
  parameter int ADDR_W   = 10,
  parameter int MIN_GAP  = 25,
  parameter int MINOR_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [MINOR_W-1:0] minor_period_i,
  output logic [ADDR_W-1:0]  list_addr_o,
  input  logic [ENTRY_W-1:0] list_entry_i,
  input  logic               async_req_i,
  input  logic [ENTRY_W-1:0] async_entry_i,
  input  logic               done_i,
  output logic               start_o,
  output logic               bus_o,
  output logic [MSG_W-1:0]   msg_o,
  output logic               async_o,
  output logic               minor_o
);
  entry_t cur_e, req_e;
  assign cur_e = entry_t'(list_entry_i);
  assign req_e = entry_t'(async_entry_i);

  logic             tick, minor_wrap, ready;
  logic             take_async, take_list, launch, restart, advance;
  logic [GAP_W-1:0] gap_sel;

  logic [ADDR_W-1:0] ptr_q;
  logic              pend_q, pend_bus_q;
  logic [MSG_W-1:0]  pend_msg_q;
  logic [GAP_W-1:0]  pend_gap_q;

  always_comb begin
    take_async = run_i && ready && pend_q;
    take_list  = run_i && ready && !pend_q;
    launch     = take_async || (take_list && cur_e.kind == K_MSG);
    restart    = take_list && cur_e.kind == K_END_MAJOR;
    gap_sel    = take_async ? pend_gap_q : cur_e.gap;
    case (cur_e.kind)
      K_MSG, K_SKIP: advance = take_list;
      K_END_MINOR:   advance = take_list && minor_wrap;
      default:       advance = 1'b0;
    endcase
  end

  bcs_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .en_i(run_i), .tick_o(tick)
  );

  bcs_minor #(.W(MINOR_W)) u_minor (
    .clk_i, .rst_ni, .en_i(run_i), .tick_i(tick), .restart_i(restart),
    .period_i(minor_period_i), .wrap_o(minor_wrap), .mark_o(minor_o)
  );

  bcs_spacing #(.GW(GAP_W), .MIN_GAP(MIN_GAP)) u_space (
    .clk_i, .rst_ni, .en_i(run_i), .tick_i(tick), .launch_i(launch),
    .gap_i(gap_sel), .done_i, .ready_o(ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ptr_q <= '0;
    else if (!run_i || restart)  ptr_q <= '0;
    else if (advance)            ptr_q <= ptr_q + 1'b1;
  end
  assign list_addr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_bus_q <= 1'b0;
      pend_msg_q <= '0;
      pend_gap_q <= '0;
    end else if (!run_i || take_async) begin
      pend_q <= 1'b0;
    end else if (async_req_i && !pend_q && req_e.kind == K_MSG) begin
      pend_q     <= 1'b1;
      pend_bus_q <= req_e.bus_b;
      pend_msg_q <= req_e.msg;
      pend_gap_q <= req_e.gap;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      async_o <= 1'b0;
      bus_o   <= 1'b0;
      msg_o   <= '0;
    end else begin
      start_o <= launch;
      async_o <= take_async;
      if (launch) begin
        bus_o <= take_async ? pend_bus_q : cur_e.bus_b;
        msg_o <= take_async ? pend_msg_q : cur_e.msg;
      end
    end
  end
endmodule

// File: rtl/bc_frame_sched_chk.sv
`timescale 1ns/1ps
module bc_frame_sched_chk #(
  parameter int TICK_DIV = 50,
  parameter int MIN_GAP  = 25,
  parameter int ADDR_W   = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              done_i,
  input logic              start_o,
  input logic              async_o,
  input logic [ADDR_W-1:0] list_addr_o
);
  localparam int LOWB = (MIN_GAP - 1) * TICK_DIV + 2;

  logic        outst_q;
  logic [31:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q <= 1'b0;
      since_q <= '1;
    end else if (!run_i) begin
      outst_q <= 1'b0;
      since_q <= '1;
    end else begin
      if (start_o)     outst_q <= 1'b1;
      else if (done_i) outst_q <= 1'b0;
      if (start_o)              since_q <= 32'd1;
      else if (since_q != '1)   since_q <= since_q + 1'b1;
    end
  end

  p_start_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_min_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && run_i) |-> since_q >= 32'(LOWB));

  p_wait_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && run_i) |-> !outst_q);

  p_async_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    async_o |-> start_o);

  p_halt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!start_o && list_addr_o == '0));
endmodule

bind bc_frame_sched bc_frame_sched_chk #(
  .TICK_DIV(TICK_DIV), .MIN_GAP(MIN_GAP), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .done_i(done_i),
  .start_o(start_o), .async_o(async_o), .list_addr_o(list_addr_o)
);

// File: tb/bc_frame_sched_test.sv
`timescale 1ns/1ps
module bc_frame_sched_test;
  import bc_sched_pkg::*;

  localparam int D = 4, MING = 5, AW = 4, MW = 16, DEPTH = 16, LOGN = 512;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, areq = 1'b0, done = 1'b0;
  logic [MW-1:0] mper = 16'd1000;
  logic [AW-1:0] addr;
  entry_t mem [DEPTH];
  entry_t aent;
  logic [ENTRY_W-1:0] lent;
  logic start, bus, asy, minor;
  logic [MSG_W-1:0] msg;

  assign lent = mem[addr];
  always #10 clk = ~clk;

  bc_frame_sched #(.TICK_DIV(D), .ADDR_W(AW), .MIN_GAP(MING), .MINOR_W(MW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .minor_period_i(mper),
    .list_addr_o(addr), .list_entry_i(lent), .async_req_i(areq),
    .async_entry_i(aent), .done_i(done), .start_o(start), .bus_o(bus),
    .msg_o(msg), .async_o(asy), .minor_o(minor)
  );

  int cyc = 0, ns = 0, nm = 0, dcnt = 0, done_dly = 3, nchk = 0, nfail = 0;
  int s_cyc [LOGN]; int s_done [LOGN]; int m_cyc [LOGN]; int m_addr [LOGN];
  logic [MSG_W-1:0] s_msg [LOGN];
  bit s_bus [LOGN]; bit s_async [LOGN];

  initial forever begin
    @(posedge clk); cyc++;
  end

  // completion responder and output monitor
  initial forever begin
    @(negedge clk);
    done = 1'b0;
    if (dcnt > 0) begin
      dcnt--;
      if (dcnt == 0) begin
        done = 1'b1;
        if (ns > 0) s_done[(ns-1)%LOGN] = cyc;
      end
    end
    if (start) begin
      s_cyc[ns%LOGN] = cyc; s_msg[ns%LOGN] = msg; s_bus[ns%LOGN] = bus;
      s_async[ns%LOGN] = asy; s_done[ns%LOGN] = -1;
      ns++; dcnt = done_dly;
    end
    if (minor) begin
      m_cyc[nm%LOGN] = cyc; m_addr[nm%LOGN] = int'(addr); nm++;
    end
  end

  function automatic entry_t mk(kind_e k, bit b, int m, int g);
    entry_t e;
    e.kind = k; e.bus_b = b; e.msg = MSG_W'(m); e.gap = GAP_W'(g);
    return e;
  endfunction

  function automatic int need_of(int g);
    return (g < MING) ? MING : g;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = mk(K_END_MAJOR, 1'b0, 0, 0);
  endtask

  task automatic halt();
    @(negedge clk) run = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic go();
    @(posedge clk); ns = 0; nm = 0;
    @(negedge clk) run = 1'b1;
  endtask

  task automatic wait_starts(input int n);
    int t;
    t = 0;
    while (ns < n && t < 20000) begin
      @(posedge clk); t++;
    end
    if (ns < n) chk(1'b0, "R2 start count", ns, n);
    @(negedge clk);
  endtask

  // expected order and launch window, derived from the list contents
  task automatic verify(input int n);
    int a, nsym, need, lo, hi, dc;
    bit skp;
    string tag;
    entry_t e, pe;
    a = 0;
    pe = mk(K_MSG, 1'b0, 0, 0);
    for (int k = 0; k < n; k++) begin
      nsym = 0; skp = 1'b0;
      for (int g = 0; g < 40 && mem[a].kind != K_MSG; g++) begin
        nsym++;
        if (mem[a].kind == K_SKIP) skp = 1'b1;
        a = (mem[a].kind == K_END_MAJOR) ? 0 : (a + 1) % DEPTH;
      end
      e = mem[a];
      a = (a + 1) % DEPTH;
      chk(s_msg[k] == e.msg && s_bus[k] == e.bus_b && !s_async[k],
          skp ? "R10 order" : "R2 message", int'(s_msg[k]), int'(e.msg));
      if (k > 0) begin
        need = need_of(int'(pe.gap));
        dc = s_done[k-1];
        lo = imax(s_cyc[k-1] + (need - 1) * D + 2, dc + 1) + nsym;
        hi = imax(s_cyc[k-1] + need * D + 1, dc + 1) + nsym;
        if (dc + 1 > s_cyc[k-1] + need * D + 1) tag = "R5 done hold";
        else if (skp) tag = "R10 skip";
        else if (need > int'(pe.gap)) tag = "R4 stretch";
        else tag = "R3 spacing";
        chk(s_cyc[k] >= lo && s_cyc[k] <= hi, tag,
            s_cyc[k] - s_cyc[k-1], lo - s_cyc[k-1]);
      end
      pe = e;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    summary();
  end

  initial begin
    int j, s0;
    bit found;
    void'($urandom(32'h1553_0A5C));
    clear_mem();
    aent = mk(K_MSG, 1'b0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!start && !asy && !minor && addr == '0, "R1 reset", int'(start), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!start && !minor && addr == '0, "R1 idle after reset", int'(addr), 0);

    // directed: spacing, stretch, skip, end of major frame
    clear_mem();
    mem[0] = mk(K_MSG, 1'b0, 'h11, 8);
    mem[1] = mk(K_SKIP, 1'b0, 0, 0);
    mem[2] = mk(K_MSG, 1'b1, 'h22, 2);
    mem[3] = mk(K_END_MAJOR, 1'b0, 0, 0);
    done_dly = 3;
    go();
    wait_starts(7);
    verify(7);
    chk(nm == 3, "R6 restart count", nm, 3);
    for (int i = 0; i < nm && i < LOGN; i++)
      chk(m_addr[i] == 0, "R6 address at restart", m_addr[i], 0);

    // late completion
    halt();
    clear_mem();
    mem[0] = mk(K_MSG, 1'b1, 'h61, 5);
    done_dly = 60;
    go();
    wait_starts(4);
    verify(4);

    // random frames with short, long and mixed completion delays
    for (int r = 0; r < 3; r++) begin
      halt();
      clear_mem();
      for (int i = 0; i < 11; i++)
        mem[i] = mk((i == 0 || ($urandom % 4) != 0) ? K_MSG : K_SKIP,
                    1'($urandom % 2), int'($urandom % 1024), int'($urandom % 13));
      done_dly = (r == 0) ? 2 : (r == 1) ? 40 : 1 + int'($urandom % 30);
      go();
      wait_starts(16);
      verify(16);
    end

    // asynchronous insertion
    halt();
    clear_mem();
    mem[0] = mk(K_MSG, 1'b0, 'h31, 10);
    mem[1] = mk(K_MSG, 1'b0, 'h32, 10);
    aent = mk(K_MSG, 1'b1, 'h3F, 6);
    done_dly = 3;
    go();
    wait_starts(1);
    areq = 1'b1;
    @(negedge clk) areq = 1'b0;
    wait_starts(3);
    chk(s_msg[0] == 'h31 && !s_async[0], "R9 first list message", int'(s_msg[0]), 'h31);
    chk(s_msg[1] == 'h3F && s_async[1] && s_bus[1], "R9 async launch", int'(s_msg[1]), 'h3F);
    chk(s_cyc[1] - s_cyc[0] >= 38 && s_cyc[1] - s_cyc[0] <= 41,
        "R9 async after spacing", s_cyc[1] - s_cyc[0], 38);
    chk(s_msg[2] == 'h32 && !s_async[2], "R9 list resumes", int'(s_msg[2]), 'h32);
    chk(s_cyc[2] - s_cyc[1] >= 22 && s_cyc[2] - s_cyc[1] <= 25,
        "R9 async spacing", s_cyc[2] - s_cyc[1], 22);

    // request while halted is dropped
    halt();
    clear_mem();
    mem[0] = mk(K_MSG, 1'b0, 'h51, 5);
    aent = mk(K_MSG, 1'b1, 'h5E, 5);
    @(posedge clk); ns = 0;
    @(negedge clk) areq = 1'b1;
    @(negedge clk) areq = 1'b0;
    repeat (10) @(negedge clk);
    chk(ns == 0, "R11 no start while halted", ns, 0);
    chk(addr == '0, "R11 address held", int'(addr), 0);
    go();
    wait_starts(2);
    chk(s_msg[0] == 'h51 && !s_async[0], "R11 first launch is entry 0", int'(s_msg[0]), 'h51);
    chk(s_msg[1] == 'h51 && !s_async[1], "R11 request dropped", int'(s_msg[1]), 'h51);

    // end of minor frame and minor period
    halt();
    clear_mem();
    mper = 16'd20;
    mem[0] = mk(K_MSG, 1'b0, 'h41, 5);
    mem[1] = mk(K_END_MINOR, 1'b0, 0, 0);
    mem[2] = mk(K_END_MINOR, 1'b0, 0, 0);
    mem[3] = mk(K_MSG, 1'b1, 'h42, 5);
    done_dly = 3;
    go();
    wait_starts(2);
    chk(s_msg[1] == 'h42 && s_bus[1], "R7 entry after boundary", int'(s_msg[1]), 'h42);
    found = 1'b0; j = 0;
    s0 = s_cyc[1];
    for (int i = 0; i < nm && i < LOGN; i++)
      if (m_cyc[i] == s0 - 1) begin found = 1'b1; j = i; end
    chk(found, "R7 start one cycle after boundary", s0, s0);
    chk(found && j > 0 && m_cyc[j] - m_cyc[j-1] == 20 * D,
        "R8 minor period", (j > 0) ? m_cyc[j] - m_cyc[j-1] : -1, 20 * D);

    halt();
    summary();
  end
endmodule